// File: doc/BRIEF.md
# Dual-Rail Zero-Substitution Line Decoder

This block sits on the receive side of a DS3/E3 line interface, between the dual-rail pulse outputs of a line receiver and the framer logic. Each enabled clock it takes one line symbol on two rails: a positive pulse, a negative pulse, no pulse, or the illegal case of both rails at once. It folds the symbol stream into single-rail NRZ data. On the way it removes the zero-substitution patterns of B3ZS (DS3 rate) or HDB3 (E3 rate), chosen by a mode input.

Line faults are reported beside the data. Any pulse that breaks alternate-mark inversion without forming a legal substitution raises a strobe, aligned with the bit it belongs to. Runs of zeros that a correct transmitter would have replaced count as excessive-zero events. A saturating counter for each kind of event is read as two bytes. The high byte is captured at the moment the low byte is read, so the pair of bytes always comes from one value.

With decoding switched off the block only delays the two rails to its output, with the same latency. In that case it makes no checks and counts nothing.

Top module: `lined_decoder`

## Requirements
- R1: After reset `out_a`, `out_b`, all four counter bytes and both error counts are zero.
- R2: With `dec_en` = 0, `out_a`/`out_b` reproduce `rail_p`/`rail_n` four enabled clock edges later (including the sampling edge), including both-high symbols, and neither counter changes.
- R3: With `dec_en` = 1, a single-rail pulse that alternates with the previous pulse (or is the first pulse after reset) appears as `out_a` = 1 with `out_b` = 0, and a zero appears as `out_a` = 0. The latency is the same four enabled edges, and `out_b` is the violation strobe for the same bit.
- R4: With `e3_mode` = 0 (B3ZS), a pulse with the same polarity as the last reference pulse, where the symbol just before it was a zero, is a substitution. It and the two symbols before it leave as zeros, with no strobe and no count.
- R5: With `e3_mode` = 1 (HDB3), a same-polarity pulse where the two symbols before it were zeros is a substitution. It and the three symbols before it leave as zeros, with no strobe and no count.
- R6: Any other same-polarity pulse is a bipolar violation. It leaves as `out_a` = 1 with `out_b` = 1, and the violation count goes up by one.
- R7: Both rails high in one symbol leaves as `out_a` = 1 with `out_b` = 1 and is counted as a violation. It does not change the polarity reference.
- R8: A run of zeros counts one excessive-zero event when it reaches 3 zeros (`e3_mode` = 0) or 4 zeros (`e3_mode` = 1), and only one per run.
- R9: While `line_ce` = 0 the data path and both counters hold, and the rails are ignored.
- R10: `*_lo` always shows bits 7:0 of the live count. `*_hi` shows bits 15:8 as captured at the last `cnt_rd_lo` edge, and holds between read strobes.
- R11: `cnt_clr` sets both counts to zero on that edge. It takes precedence over an event in the same cycle.
- R12: Each count stops at 0xFFFF and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_ce | input | 1 | Line symbol enable |
| rail_p | input | 1 | Positive pulse rail |
| rail_n | input | 1 | Negative pulse rail |
| e3_mode | input | 1 | 0 = B3ZS, 1 = HDB3 |
| dec_en | input | 1 | 1 = decode, 0 = rail pass-through |
| cnt_rd_lo | input | 1 | Low-byte read strobe, captures high bytes |
| cnt_clr | input | 1 | Clears both counts |
| out_a | output | 1 | NRZ data, or delayed positive rail |
| out_b | output | 1 | Violation strobe, or delayed negative rail |
| bpv_lo | output | 8 | Violation count, live low byte |
| bpv_hi | output | 8 | Violation count, captured high byte |
| exz_lo | output | 8 | Excessive-zero count, live low byte |
| exz_hi | output | 8 | Excessive-zero count, captured high byte |

## Verification
The assertions take for granted that `dec_en` and `e3_mode` are static while symbols stream. A change in mid-stream would mix stages decoded under different rules, and the pass-through quiet check would then be judged against a mode that no longer applies. The stimulus therefore sets both inputs only while reset is held and the line enable is low. Between groups it resets the block, so the polarity reference and the zero-run length always start from their reset values.

// File: rtl/lined_pkg.sv
package lined_pkg;
  // Symbol pipeline depth: the sampled stage plus three look-back stages.
  localparam int WIN_DEPTH = 4;
  localparam int WIN_HIST  = WIN_DEPTH - 1;
  // Number of earlier symbols rewritten by a valid substitution.
  localparam int SUB_BACK_B3 = 2;
  localparam int SUB_BACK_H3 = 3;
  // Zero-run lengths that count as excessive.
  localparam int EXZ_RUN_B3 = 3;
  localparam int EXZ_RUN_H3 = 4;
  localparam int RUN_W      = 3;

  typedef struct packed {
    logic pos;
    logic neg;
    logic dat;
    logic viol;
  } lined_stage_t;
endpackage

// File: rtl/lined_sub_detect.sv
module lined_sub_detect
  import lined_pkg::*;
#(
  parameter int HIST = WIN_HIST
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce,
  input  logic            dec_en,
  input  logic            e3_mode,
  input  logic            rail_p,
  input  logic            rail_n,
  input  logic [HIST-1:0] hist_nz,
  output logic            new_dat,
  output logic            new_viol,
  output logic [HIST-1:0] clr_mask,
  output logic            bpv_evt
);
  logic last_neg_q, last_neg_d;
  logic seen_q, seen_d;
  logic single, both, same_pol, sub_ok, sub_hit;
  int   back_n;

  always_comb begin
    single   = rail_p ^ rail_n;
    both     = rail_p & rail_n;
    same_pol = dec_en & single & seen_q & (rail_n == last_neg_q);
    if (e3_mode) begin
      sub_ok = ~hist_nz[0] & ~hist_nz[1];
      back_n = SUB_BACK_H3;
    end else begin
      sub_ok = ~hist_nz[0];
      back_n = SUB_BACK_B3;
    end
    sub_hit  = same_pol & sub_ok;
    new_dat  = dec_en & (rail_p | rail_n) & ~sub_hit;
    new_viol = dec_en & (both | (same_pol & ~sub_ok));
    bpv_evt  = ce & new_viol;
    for (int i = 0; i < HIST; i++) begin
      clr_mask[i] = sub_hit & (i < back_n);
    end
  end

  always_comb begin
    last_neg_d = last_neg_q;
    seen_d     = seen_q;
    if (ce && dec_en && single && !same_pol) begin
      last_neg_d = rail_n;
      seen_d     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_neg_q <= 1'b0;
      seen_q     <= 1'b0;
    end else begin
      last_neg_q <= last_neg_d;
      seen_q     <= seen_d;
    end
  end
endmodule

// File: rtl/lined_window.sv
module lined_window
  import lined_pkg::*;
#(
  parameter int DEPTH = WIN_DEPTH,
  localparam int HIST = DEPTH - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce,
  input  logic            rail_p,
  input  logic            rail_n,
  input  logic            new_dat,
  input  logic            new_viol,
  input  logic [HIST-1:0] clr_mask,
  output logic [HIST-1:0] hist_nz,
  output logic            tail_pos,
  output logic            tail_neg,
  output logic            tail_dat,
  output logic            tail_viol
);
  lined_stage_t stage_q [DEPTH];
  lined_stage_t stage_d [DEPTH];

  always_comb begin
    stage_d[0].pos  = rail_p;
    stage_d[0].neg  = rail_n;
    stage_d[0].dat  = new_dat;
    stage_d[0].viol = new_viol;
    for (int i = 1; i < DEPTH; i++) begin
      stage_d[i]     = stage_q[i-1];
      stage_d[i].dat = stage_q[i-1].dat & ~clr_mask[i-1];
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= '0;
        end else if (ce) begin
          stage_q[g] <= stage_d[g];
        end
      end
    end
    for (genvar h = 0; h < HIST; h++) begin : g_hist
      assign hist_nz[h] = stage_q[h].pos | stage_q[h].neg;
    end
  endgenerate

  assign tail_pos  = stage_q[DEPTH-1].pos;
  assign tail_neg  = stage_q[DEPTH-1].neg;
  assign tail_dat  = stage_q[DEPTH-1].dat;
  assign tail_viol = stage_q[DEPTH-1].viol;
endmodule

// File: rtl/lined_zero_run.sv
module lined_zero_run
  import lined_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic dec_en,
  input  logic e3_mode,
  input  logic pulse,
  output logic exz_evt
);
  logic [RUN_W-1:0] run_q, run_d, limit;

  always_comb begin
    limit   = e3_mode ? RUN_W'(EXZ_RUN_H3) : RUN_W'(EXZ_RUN_B3);
    run_d   = run_q;
    exz_evt = 1'b0;
    if (ce && dec_en) begin
      if (pulse) begin
        run_d = '0;
      end else begin
        exz_evt = (run_q == limit - RUN_W'(1));
        if (run_q != limit) run_d = run_q + RUN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end
endmodule

// File: rtl/lined_err_counter.sv
module lined_err_counter #(
  parameter int CNT_W = 16,
  localparam int HALF = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  input  logic             rd_lo,
  output logic [CNT_W-1:0] cnt_o,
  output logic [HALF-1:0]  lo_o,
  output logic [HALF-1:0]  hi_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [HALF-1:0]  hi_q, hi_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                         cnt_d = '0;
    else if (inc && cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
    hi_d = rd_lo ? cnt_q[CNT_W-1:HALF] : hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hi_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      hi_q  <= hi_d;
    end
  end

  assign cnt_o = cnt_q;
  assign lo_o  = cnt_q[HALF-1:0];
  assign hi_o  = hi_q;
endmodule

// File: rtl/lined_decoder.sv
module lined_decoder
  import lined_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int BYTE_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_ce,
  input  logic              rail_p,
  input  logic              rail_n,
  input  logic              e3_mode,
  input  logic              dec_en,
  input  logic              cnt_rd_lo,
  input  logic              cnt_clr,
  output logic              out_a,
  output logic              out_b,
  output logic [BYTE_W-1:0] bpv_lo,
  output logic [BYTE_W-1:0] bpv_hi,
  output logic [BYTE_W-1:0] exz_lo,
  output logic [BYTE_W-1:0] exz_hi
);
  logic [WIN_HIST-1:0] hist_nz, clr_mask;
  logic new_dat, new_viol, bpv_evt, exz_evt;
  logic win_pos, win_neg, win_dat, win_viol;
  logic [CNT_W-1:0] bpv_cnt, exz_cnt;

  lined_sub_detect #(.HIST(WIN_HIST)) u_detect (
    .clk(clk), .rst_n(rst_n), .ce(line_ce), .dec_en(dec_en), .e3_mode(e3_mode),
    .rail_p(rail_p), .rail_n(rail_n), .hist_nz(hist_nz),
    .new_dat(new_dat), .new_viol(new_viol), .clr_mask(clr_mask), .bpv_evt(bpv_evt)
  );

  lined_window #(.DEPTH(WIN_DEPTH)) u_window (
    .clk(clk), .rst_n(rst_n), .ce(line_ce), .rail_p(rail_p), .rail_n(rail_n),
    .new_dat(new_dat), .new_viol(new_viol), .clr_mask(clr_mask), .hist_nz(hist_nz),
    .tail_pos(win_pos), .tail_neg(win_neg), .tail_dat(win_dat), .tail_viol(win_viol)
  );

  lined_zero_run u_zrun (
    .clk(clk), .rst_n(rst_n), .ce(line_ce), .dec_en(dec_en), .e3_mode(e3_mode),
    .pulse(rail_p | rail_n), .exz_evt(exz_evt)
  );

  lined_err_counter #(.CNT_W(CNT_W)) u_bpv_cnt (
    .clk(clk), .rst_n(rst_n), .inc(bpv_evt), .clr(cnt_clr), .rd_lo(cnt_rd_lo),
    .cnt_o(bpv_cnt), .lo_o(bpv_lo), .hi_o(bpv_hi)
  );

  lined_err_counter #(.CNT_W(CNT_W)) u_exz_cnt (
    .clk(clk), .rst_n(rst_n), .inc(exz_evt), .clr(cnt_clr), .rd_lo(cnt_rd_lo),
    .cnt_o(exz_cnt), .lo_o(exz_lo), .hi_o(exz_hi)
  );

  assign out_a = dec_en ? win_dat  : win_pos;
  assign out_b = dec_en ? win_viol : win_neg;
endmodule

// File: rtl/lined_decoder_chk.sv
module lined_decoder_chk #(
  parameter int CNT_W = 16,
  localparam int BYTE_W = CNT_W / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_ce,
  input logic              dec_en,
  input logic              cnt_clr,
  input logic              cnt_rd_lo,
  input logic              win_dat,
  input logic              win_viol,
  input logic [CNT_W-1:0]  bpv_cnt,
  input logic [CNT_W-1:0]  exz_cnt,
  input logic [BYTE_W-1:0] bpv_hi,
  input logic [BYTE_W-1:0] exz_hi
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_en && !cnt_clr) |=> ($stable(bpv_cnt) && $stable(exz_cnt))); // R2

  AST_CE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_ce && !cnt_clr) |=> ($stable(win_dat) && $stable(win_viol) && $stable(bpv_cnt) && $stable(exz_cnt))); // R9

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> ((bpv_cnt == $past(bpv_cnt)) || (bpv_cnt == $past(bpv_cnt) + 1'b1))); // R6

  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_rd_lo |=> ($stable(bpv_hi) && $stable(exz_hi))); // R10

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (bpv_cnt == '0 && exz_cnt == '0)); // R11

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bpv_cnt == CMAX && exz_cnt == CMAX && !cnt_clr) |=> (bpv_cnt == CMAX && exz_cnt == CMAX)); // R12

  AST_BPV_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (bpv_cnt == CMAX && !cnt_clr) |=> (bpv_cnt == CMAX)); // R12
endmodule

bind lined_decoder lined_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_ce(line_ce), .dec_en(dec_en),
  .cnt_clr(cnt_clr), .cnt_rd_lo(cnt_rd_lo), .win_dat(win_dat), .win_viol(win_viol),
  .bpv_cnt(bpv_cnt), .exz_cnt(exz_cnt), .bpv_hi(bpv_hi), .exz_hi(exz_hi)
);

// File: tb/lined_decoder_bench.sv
module lined_decoder_bench;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, line_ce = 1'b0, rail_p = 1'b0, rail_n = 1'b0;
  logic e3_mode = 1'b0, dec_en = 1'b0, cnt_rd_lo = 1'b0, cnt_clr = 1'b0;
  logic out_a, out_b;
  logic [7:0] bpv_lo, bpv_hi, exz_lo, exz_hi;

  lined_decoder #(.CNT_W(CNT_W)) u_lined_decoder (
    .clk(clk), .rst_n(rst_n), .line_ce(line_ce), .rail_p(rail_p), .rail_n(rail_n),
    .e3_mode(e3_mode), .dec_en(dec_en), .cnt_rd_lo(cnt_rd_lo), .cnt_clr(cnt_clr),
    .out_a(out_a), .out_b(out_b), .bpv_lo(bpv_lo), .bpv_hi(bpv_hi),
    .exz_lo(exz_lo), .exz_hi(exz_hi)
  );

  typedef struct {
    logic   a;
    logic   b;
    longint due;
    string  tag;
  } exp_t;

  exp_t   sb_q[$];
  exp_t   pend[$];
  int     n_chk = 0, n_err = 0;
  longint ecyc = 0;
  bit     done = 1'b0;

  // reference model state
  bit m_e3, m_dec, m_seen, m_lastneg;
  bit m_h0, m_h1, m_h2;
  int m_zrun, m_bpv, m_exz;

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n && line_ce) ecyc <= ecyc + 1;

  // monitor: compares scoreboard items once their enabled-edge count is due
  always @(posedge clk) begin
    #3;
    while (sb_q.size() > 0 && sb_q[0].due <= ecyc) begin
      exp_t it;
      it = sb_q.pop_front();
      check({it.tag, " out_a"}, out_a, it.a);
      check({it.tag, " out_b"}, out_b, it.b);
    end
  end

  task automatic model_reset();
    m_seen = 0; m_lastneg = 0; m_h0 = 0; m_h1 = 0; m_h2 = 0;
    m_zrun = 0; m_bpv = 0; m_exz = 0;
  endtask

  // driver: computes the expected item, drives the symbol, queues the result
  task automatic step(input logic p, input logic n, input string tag);
    exp_t it;
    int   thr;
    bit   ok;
    thr = m_e3 ? 4 : 3;
    it.tag = tag;
    if (!m_dec) begin
      it.a = p; it.b = n;
    end else if (p && n) begin
      it.a = 1; it.b = 1; m_bpv++; m_zrun = 0;           // R7
    end else if (p || n) begin
      m_zrun = 0;
      if (m_seen && (n == m_lastneg)) begin
        ok = m_e3 ? (!m_h0 && !m_h1) : !m_h0;
        if (ok) begin                                     // R4 / R5
          it.a = 0; it.b = 0;
          for (int k = 0; k < (m_e3 ? 3 : 2); k++) begin
            if (pend.size() > k) begin
              exp_t t;
              t = pend[pend.size()-1-k];
              t.a = 0;
              pend[pend.size()-1-k] = t;
            end
          end
        end else begin                                    // R6
          it.a = 1; it.b = 1; m_bpv++;
        end
      end else begin                                      // R3
        it.a = 1; it.b = 0; m_seen = 1; m_lastneg = n;
      end
    end else begin
      it.a = 0; it.b = 0;
      m_zrun++;
      if (m_zrun == thr) m_exz++;                         // R8
    end
    m_h2 = m_h1; m_h1 = m_h0; m_h0 = p | n;
    @(negedge clk);
    rail_p = p; rail_n = n; line_ce = 1'b1;
    it.due = ecyc + 4;
    pend.push_back(it);
    if (pend.size() > 3) sb_q.push_back(pend.pop_front());
  endtask

  task automatic end_group();
    repeat (7) step(1'b0, 1'b0, "tail");
    pend.delete();
    @(negedge clk);
    line_ce = 1'b0; rail_p = 1'b0; rail_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset(input bit e3, input bit dec);
    @(negedge clk);
    rst_n = 1'b0; line_ce = 1'b0; rail_p = 1'b0; rail_n = 1'b0;
    cnt_rd_lo = 1'b0; cnt_clr = 1'b0;
    e3_mode = e3; dec_en = dec; m_e3 = e3; m_dec = dec;
    model_reset();
    sb_q.delete(); pend.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic read_lo();
    @(negedge clk); cnt_rd_lo = 1'b1;
    @(negedge clk); cnt_rd_lo = 1'b0;
  endtask

  task automatic check_counts(string req);
    read_lo();
    check({req, " bpv_lo"}, bpv_lo, m_bpv & 8'hFF);
    check({req, " bpv_hi"}, bpv_hi, (m_bpv >> 8) & 8'hFF);
    check({req, " exz_lo"}, exz_lo, m_exz & 8'hFF);
    check({req, " exz_hi"}, exz_hi, (m_exz >> 8) & 8'hFF);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic sa, sb;
    logic [7:0] sl;
    // R1: reset state
    do_reset(1'b0, 1'b1);
    check("R1 out_a", out_a, 0);
    check("R1 out_b", out_b, 0);
    check("R1 bpv_lo", bpv_lo, 0);
    check("R1 bpv_hi", bpv_hi, 0);
    check("R1 exz_lo", exz_lo, 0);
    check("R1 exz_hi", exz_hi, 0);

    // B3ZS group: R3 R4 R6 R7 R8
    step(1,0,"R3"); step(0,0,"R3"); step(0,1,"R3");
    step(0,0,"R4"); step(0,0,"R4"); step(0,1,"R4");          // 00V
    step(1,0,"R4"); step(0,0,"R4"); step(1,0,"R4");          // B0V
    step(0,1,"R3"); step(1,0,"R3"); step(1,0,"R6");          // adjacent same polarity
    step(0,0,"R8"); step(0,0,"R8"); step(0,0,"R8"); step(0,0,"R8");
    step(1,1,"R7"); step(0,1,"R7");                          // reference still P after both-high
    end_group();
    check("R6 model bpv", m_bpv, 2);
    check("R8 model exz", m_exz, 2);
    check_counts("R6 R8 b3zs");

    // HDB3 group: R5 R6 R8
    do_reset(1'b1, 1'b1);
    step(1,0,"R3"); step(0,0,"R5"); step(0,0,"R5"); step(0,0,"R5"); step(1,0,"R5"); // 000V
    step(0,1,"R5"); step(0,0,"R5"); step(0,0,"R5"); step(0,1,"R5");                 // B00V
    step(1,0,"R3"); step(0,0,"R6"); step(1,0,"R6");                                 // V one zero apart
    step(1,0,"R6");
    step(0,0,"R8"); step(0,0,"R8"); step(0,0,"R8"); step(0,0,"R8"); step(0,0,"R8");
    step(0,1,"R3");
    end_group();
    check_counts("R5 R8 hdb3");

    // bypass group: R2
    do_reset(1'b0, 1'b0);
    step(1,0,"R2"); step(1,0,"R2"); step(1,1,"R2"); step(0,1,"R2");
    step(0,0,"R2"); step(0,0,"R2"); step(0,0,"R2"); step(0,0,"R2"); step(0,1,"R2");
    end_group();
    check_counts("R2 bypass");
    check("R2 bpv_lo zero", bpv_lo, 0);
    check("R2 exz_lo zero", exz_lo, 0);

    // clock enable hold: R9
    do_reset(1'b0, 1'b1);
    step(1,0,"R9"); step(1,0,"R9"); step(0,1,"R9"); step(1,1,"R9");
    @(negedge clk);
    line_ce = 1'b0;
    @(negedge clk);
    sa = out_a; sb = out_b; sl = bpv_lo;
    for (int i = 0; i < 5; i++) begin
      rail_p = 1'b1; rail_n = (i % 2 == 0);
      @(negedge clk);
      check("R9 out_a hold", out_a, sa);
      check("R9 out_b hold", out_b, sb);
      check("R9 bpv_lo hold", bpv_lo, sl);
    end
    step(0,0,"R9"); step(1,0,"R9");
    end_group();
    check_counts("R9 after hold");

    // byte latch and clear: R10 R11
    do_reset(1'b0, 1'b1);
    for (int i = 0; i < 300; i++) step(1,1,"R7");
    end_group();
    check_counts("R10 first");
    check("R10 lo 300", bpv_lo, 44);
    check("R10 hi 300", bpv_hi, 1);
    for (int i = 0; i < 256; i++) step(1,1,"R7");
    end_group();
    check("R10 lo live", bpv_lo, 44);
    check("R10 hi held", bpv_hi, 1);
    read_lo();
    check("R10 hi after read", bpv_hi, 2);
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    m_bpv = 0; m_exz = 0;
    check("R11 bpv_lo", bpv_lo, 0);
    check("R11 exz_lo", exz_lo, 0);
    read_lo();
    check("R11 bpv_hi", bpv_hi, 0);
    // R11 precedence: clear in the same cycle as a violation
    step(1,1,"R11");
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0; line_ce = 1'b0;
    check("R11 precedence", bpv_lo, 0);

    // saturation: R12
    do_reset(1'b0, 1'b1);
    for (int i = 0; i < 65600; i++) step(1,1,"R12");
    end_group();
    read_lo();
    check("R12 bpv_lo", bpv_lo, 8'hFF);
    check("R12 bpv_hi", bpv_hi, 8'hFF);
    check("R12 exz_lo", exz_lo, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule